// File: doc/BRIEF.md
# Bus Bridge Quiesce and Reset Sequencer

This controller brings one sub-block up and down when that sub-block talks to the rest of the chip through an asynchronous bus bridge. The bridge has two independent sides, master and slave. Each side has a stop-request line driven by this block and an acknowledge line returned by the bridge. The controller also owns the sub-block's clock-enable and its active-low reset. A caller issues single-cycle requests to power up, power down or reset the sub-block. The block answers each request with a one-cycle `done` or `err` pulse.

To power up, the controller raises both stop requests and clocks the sub-block for `PULSE_CYCLES` cycles with reset held. It then gates the clock, releases reset with the clock still gated, and restarts the clock. Next it lowers the master-side stop request and waits for the master acknowledge to fall. Only after that does it lower the slave-side request and wait for the slave acknowledge to fall. Power-down runs the other way: the slave side is stopped first, then the master side, then the clock is gated and reset is asserted. Every acknowledge wait is bounded by `ACK_TIMEOUT` cycles. A timeout unwinds only the steps that already completed, and the unwind differs by step. A reset request runs a full power-down and then a full power-up, and it is accepted only while the parent power island reports on. Both acknowledge inputs pass through a `SYNC_STAGES` synchronizer before the controller compares them.

States: `ST_OFF`, `ST_ON` (idle); `ST_ON_PULSE`, `ST_ON_GATE`, `ST_ON_RELEASE`, `ST_ON_MST`, `ST_ON_SLV` (power-up); `ST_UNDO_MST` (slave-enable unwind); `ST_OFF_SLV`, `ST_OFF_MST`, `ST_OFF_GATE` (power-down); `ST_REEN_SLV` (master-disable unwind).

Transitions:
- `ST_OFF` goes to `ST_ON_PULSE` on a power-up request.
- `ST_ON` goes to `ST_OFF_SLV` on a power-down request, or on an accepted reset request.
- The power-up states advance in order: `ST_ON_PULSE`, `ST_ON_GATE`, `ST_ON_RELEASE`, `ST_ON_MST`, `ST_ON_SLV`, then `ST_ON`.
- `ST_ON_MST` goes to `ST_OFF` on timeout.
- `ST_ON_SLV` goes to `ST_UNDO_MST` on timeout, and `ST_UNDO_MST` then goes to `ST_OFF`.
- `ST_OFF_SLV` goes to `ST_ON` on timeout.
- `ST_OFF_MST` goes to `ST_OFF_GATE` on acknowledge, or to `ST_REEN_SLV` on timeout. `ST_REEN_SLV` then goes to `ST_ON`.
- `ST_OFF_GATE` goes to `ST_OFF`, or to `ST_ON_PULSE` when the power-down is part of a reset cycle.

Top module: `bridge_quiesce_seq`

## Requirements
- R1: After reset the clock-enable is 0, the sub-block reset is asserted (`sub_rst_n`=0), both stop requests are 1, and `done` and `err` are 0.
- R2: A power-up holds the sub-block in reset with the clock enabled for exactly `PULSE_CYCLES` cycles. Reset is released only in a cycle where the clock-enable is 0.
- R3: During power-up the master stop request falls strictly before the slave stop request. A successful power-up ends with `done`, clock-enable 1, `sub_rst_n` 1 and both stop requests 0.
- R4: A power-down raises the slave stop request strictly before the master stop request. On success it ends with `done`, clock-enable 0, `sub_rst_n` 0 and both stop requests 1. Reset is asserted only while the clock is gated.
- R5: An acknowledge that does not reach its target level within `ACK_TIMEOUT` cycles ends the operation with an `err` pulse. `done` and `err` are never high together.
- R6: If the master side fails to un-stop during power-up, the result is clock-enable 0, reset asserted, master stop 0 and slave stop 1.
- R7: If the slave side fails to un-stop during power-up, the master stop request is raised again. The result is clock-enable 0, reset asserted, master stop 1 and slave stop 0.
- R8: If the slave side fails to stop during power-down, the block returns to on with its slave stop request left at 1. If the master side fails to stop, the slave stop request is lowered again. In both cases reset stays deasserted and the clock keeps running.
- R9: A reset request in the on state with `island_on`=1 performs a power-down and then a power-up, ending with `done` in the on state. It is refused with `err`, and no output changes, when `island_on`=0 or when the block is off.
- R10: Requests in the same cycle are served with priority reset, then power-down, then power-up. Requests that arrive while a sequence is running are ignored.
- R11: `rst_status` is 1 exactly when the sub-block reset is asserted.
- R12: A power-up request while on, or a power-down request while off, gives `done` without changing any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low controller reset |
| island_on | input | 1 | Parent power island is up |
| pwr_on_req | input | 1 | Single-cycle power-up request |
| pwr_off_req | input | 1 | Single-cycle power-down request |
| rst_req | input | 1 | Single-cycle sub-block reset request |
| mst_ack | input | 1 | Master-side bridge acknowledge (asynchronous) |
| slv_ack | input | 1 | Slave-side bridge acknowledge (asynchronous) |
| mst_stop | output | 1 | Master-side stop request |
| slv_stop | output | 1 | Slave-side stop request |
| sub_clk_en | output | 1 | Sub-block clock enable |
| sub_rst_n | output | 1 | Sub-block active-low reset |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle failure or refusal pulse |
| rst_status | output | 1 | High while the sub-block reset is asserted |

## Verification
Two functions can collide in one cycle. The first is request arbitration: reset, power-down and power-up requests can reach the idle state together. The second is request intake while a sequence is already running. The bench raises all three request lines on one edge, in both the on state and the off state. It judges the result by the final output state and by whether a reset pulse (`PULSE_CYCLES` clock cycles under reset) appeared. It also fires a power-down request in the middle of a power-up. There it requires the power-up to finish normally and the outputs to stay on afterwards.

// File: rtl/bqs_pkg.sv
package bqs_pkg;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_ON_PULSE,
        ST_ON_GATE,
        ST_ON_RELEASE,
        ST_ON_MST,
        ST_ON_SLV,
        ST_UNDO_MST,
        ST_ON,
        ST_OFF_SLV,
        ST_OFF_MST,
        ST_REEN_SLV,
        ST_OFF_GATE
    } seq_state_e;

endpackage

// File: rtl/ack_sync.sv
module ack_sync #(
    parameter int STAGES  = 2,
    parameter int WIDTH   = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] sr;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= {STAGES{RST_VAL}};
            else        sr <= {sr[STAGES-2:0], din[i]};
        end
        assign dout[i] = sr[STAGES-1];
    end

endmodule

// File: rtl/step_timer.sv
module step_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/bridge_quiesce_seq.sv
module bridge_quiesce_seq
    import bqs_pkg::*;
#(
    parameter int PULSE_CYCLES = 32,
    parameter int ACK_TIMEOUT  = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic island_on,
    input  logic pwr_on_req,
    input  logic pwr_off_req,
    input  logic rst_req,
    input  logic mst_ack,
    input  logic slv_ack,
    output logic mst_stop,
    output logic slv_stop,
    output logic sub_clk_en,
    output logic sub_rst_n,
    output logic done,
    output logic err,
    output logic rst_status
);

    localparam int LIMIT = (PULSE_CYCLES > ACK_TIMEOUT) ? PULSE_CYCLES : ACK_TIMEOUT;
    localparam int TW    = $clog2(LIMIT + 1);

    seq_state_e state, state_n;
    logic       cycle_q, cycle_n;
    logic       done_n, err_n;
    logic [1:0] ack_s;
    logic       mst_ack_s, slv_ack_s;
    logic       tmr_load, tmr_exp;
    logic [TW-1:0] tmr_val;

    ack_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({slv_ack, mst_ack}),
        .dout (ack_s)
    );
    assign mst_ack_s = ack_s[0];
    assign slv_ack_s = ack_s[1];

    assign tmr_load = (state_n != state);
    assign tmr_val  = (state_n == ST_ON_PULSE) ? TW'(PULSE_CYCLES - 1) : TW'(ACK_TIMEOUT - 1);

    step_timer #(.W(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_exp)
    );

    always_comb begin
        state_n = state;
        cycle_n = cycle_q;
        done_n  = 1'b0;
        err_n   = 1'b0;
        unique case (state)
            ST_OFF: begin
                cycle_n = 1'b0;
                if (rst_req)          err_n   = 1'b1;
                else if (pwr_off_req) done_n  = 1'b1;
                else if (pwr_on_req)  state_n = ST_ON_PULSE;
            end
            ST_ON: begin
                cycle_n = 1'b0;
                if (rst_req) begin
                    if (island_on) begin
                        state_n = ST_OFF_SLV;
                        cycle_n = 1'b1;
                    end else begin
                        err_n = 1'b1;
                    end
                end
                else if (pwr_off_req) state_n = ST_OFF_SLV;
                else if (pwr_on_req)  done_n  = 1'b1;
            end
            ST_ON_PULSE:   if (tmr_exp) state_n = ST_ON_GATE;
            ST_ON_GATE:    state_n = ST_ON_RELEASE;
            ST_ON_RELEASE: state_n = ST_ON_MST;
            ST_ON_MST: begin
                if (!mst_ack_s) state_n = ST_ON_SLV;
                else if (tmr_exp) begin
                    state_n = ST_OFF;
                    err_n   = 1'b1;
                end
            end
            ST_ON_SLV: begin
                if (!slv_ack_s) begin
                    state_n = ST_ON;
                    done_n  = 1'b1;
                end
                else if (tmr_exp) state_n = ST_UNDO_MST;
            end
            ST_UNDO_MST: begin
                if (mst_ack_s || tmr_exp) begin
                    state_n = ST_OFF;
                    err_n   = 1'b1;
                end
            end
            ST_OFF_SLV: begin
                if (slv_ack_s) state_n = ST_OFF_MST;
                else if (tmr_exp) begin
                    state_n = ST_ON;
                    err_n   = 1'b1;
                end
            end
            ST_OFF_MST: begin
                if (mst_ack_s)    state_n = ST_OFF_GATE;
                else if (tmr_exp) state_n = ST_REEN_SLV;
            end
            ST_REEN_SLV: begin
                if (!slv_ack_s || tmr_exp) begin
                    state_n = ST_ON;
                    err_n   = 1'b1;
                end
            end
            ST_OFF_GATE: begin
                if (cycle_q) state_n = ST_ON_PULSE;
                else begin
                    state_n = ST_OFF;
                    done_n  = 1'b1;
                end
            end
            default: state_n = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_OFF;
            cycle_q <= 1'b0;
        end else begin
            state   <= state_n;
            cycle_q <= cycle_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_clk_en <= 1'b0;
            sub_rst_n  <= 1'b0;
            mst_stop   <= 1'b1;
            slv_stop   <= 1'b1;
            done       <= 1'b0;
            err        <= 1'b0;
        end else begin
            done <= done_n;
            err  <= err_n;
            unique case (state_n)
                ST_ON_PULSE: begin
                    sub_clk_en <= 1'b1;
                    sub_rst_n  <= 1'b0;
                    mst_stop   <= 1'b1;
                    slv_stop   <= 1'b1;
                end
                ST_ON_GATE:    sub_clk_en <= 1'b0;
                ST_ON_RELEASE: sub_rst_n  <= 1'b1;
                ST_ON_MST: begin
                    sub_clk_en <= 1'b1;
                    mst_stop   <= 1'b0;
                end
                ST_ON_SLV:   slv_stop <= 1'b0;
                ST_UNDO_MST: mst_stop <= 1'b1;
                ST_OFF_SLV:  slv_stop <= 1'b1;
                ST_OFF_MST:  mst_stop <= 1'b1;
                ST_REEN_SLV: slv_stop <= 1'b0;
                ST_OFF_GATE, ST_OFF: begin
                    sub_clk_en <= 1'b0;
                    sub_rst_n  <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign rst_status = ~sub_rst_n;

    // R2: reset is released only while the clock is gated
    assert_release_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sub_rst_n) |-> !sub_clk_en);

    // R3: the master side un-stops only while the slave side is still stopped
    assert_master_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mst_stop) |-> slv_stop);

    // R4: the master side is stopped only after the slave side was stopped
    assert_slave_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF_MST) |-> slv_stop);

    // R4: reset is asserted only with the clock gated
    assert_reset_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sub_rst_n) |-> !sub_clk_en);

    // R5: one outcome per operation
    assert_single_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    // R9: reset refused while the parent island is down
    assert_refuse_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ON && rst_req && !island_on) |=> (err && sub_rst_n && sub_clk_en));

endmodule

// File: tb/bridge_quiesce_seq_tb.sv
module bridge_quiesce_seq_tb;

    localparam int PULSE = 32;
    localparam int TMO   = 16;
    localparam int SYNC  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic island_on = 1'b1;
    logic pwr_on_req = 1'b0, pwr_off_req = 1'b0, rst_req = 1'b0;
    logic mst_ack = 1'b1, slv_ack = 1'b1;
    logic mst_stop, slv_stop, sub_clk_en, sub_rst_n, done, err, rst_status;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bridge_quiesce_seq #(.PULSE_CYCLES(PULSE), .ACK_TIMEOUT(TMO), .SYNC_STAGES(SYNC)) u_dut (
        .clk(clk), .rst_n(rst_n), .island_on(island_on),
        .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req), .rst_req(rst_req),
        .mst_ack(mst_ack), .slv_ack(slv_ack),
        .mst_stop(mst_stop), .slv_stop(slv_stop), .sub_clk_en(sub_clk_en),
        .sub_rst_n(sub_rst_n), .done(done), .err(err), .rst_status(rst_status)
    );

    // bridge model: each ack follows its stop request after a delay unless stuck
    int  dly_m = 0, dly_s = 0, cnt_m = 0, cnt_s = 0;
    bit  stuck_m = 1'b0, stuck_s = 1'b0;
    always @(negedge clk) begin
        if (!stuck_m && mst_ack != mst_stop) begin
            if (cnt_m >= dly_m) begin mst_ack <= mst_stop; cnt_m <= 0; end
            else cnt_m <= cnt_m + 1;
        end else cnt_m <= 0;
        if (!stuck_s && slv_ack != slv_stop) begin
            if (cnt_s >= dly_s) begin slv_ack <= slv_stop; cnt_s <= 0; end
            else cnt_s <= cnt_s + 1;
        end else cnt_s <= 0;
    end

    // monitors: cumulative counters and edge time stamps
    int cyc = 0, pulse_total = 0, bad_release = 0, rst_low_total = 0;
    int mst_fall = 0, slv_fall = 0, mst_rise = 0, slv_rise = 0;
    logic p_mst = 1'b1, p_slv = 1'b1, p_rst = 1'b0;
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (sub_clk_en && !sub_rst_n) pulse_total <= pulse_total + 1;
        if (!sub_rst_n) rst_low_total <= rst_low_total + 1;
        if (sub_rst_n && !p_rst && sub_clk_en) bad_release <= bad_release + 1;
        if (p_mst && !mst_stop) mst_fall <= cyc;
        if (p_slv && !slv_stop) slv_fall <= cyc;
        if (!p_mst && mst_stop) mst_rise <= cyc;
        if (!p_slv && slv_stop) slv_rise <= cyc;
        p_mst <= mst_stop; p_slv <= slv_stop; p_rst <= sub_rst_n;
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int outs();
        return {28'd0, sub_clk_en, sub_rst_n, mst_stop, slv_stop};
    endfunction

    // expected output nibble {clk_en, rst_n, mst_stop, slv_stop}
    function automatic int exp_outs(input bit clk_on, input bit rst_off, input bit ms, input bit ss);
        return {28'd0, clk_on, rst_off, ms, ss};
    endfunction

    // result: 1 done, 2 err, 0 no answer
    task automatic run_op(input bit on, input bit off, input bit rr, output int res);
        @(negedge clk); #1;
        pwr_on_req = on; pwr_off_req = off; rst_req = rr;
        @(negedge clk); #1;
        pwr_on_req = 0; pwr_off_req = 0; rst_req = 0;
        res = 0;
        for (int i = 0; i < 600; i++) begin
            if (done) begin res = 1; break; end
            if (err)  begin res = 2; break; end
            @(negedge clk); #1;
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int res, p0, b0, r0, t0, seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        #1;
        // R1 / R11 reset state
        chk("R1", "outputs in reset", outs(), exp_outs(0, 0, 1, 1));
        chk("R1", "done/err in reset", {30'd0, done, err}, 0);
        chk("R11", "rst_status in reset", rst_status, 1);
        rst_n = 1'b1;
        settle(4);
        chk("R1", "outputs after reset", outs(), exp_outs(0, 0, 1, 1));

        // main function with random bridge delays
        for (int it = 0; it < 6; it++) begin
            dly_m = $urandom_range(0, 6); dly_s = $urandom_range(0, 6);
            p0 = pulse_total; b0 = bad_release; t0 = cyc;
            run_op(1, 0, 0, res);
            chk("R3", "power-up result", res, 1);
            chk("R2", "pulse cycles under reset", pulse_total - p0, PULSE);
            chk("R2", "release with clock gated", bad_release - b0, 0);
            chk("R3", "master un-stops before slave", int'(slv_fall > mst_fall && mst_fall > t0), 1);
            chk("R3", "outputs after power-up", outs(), exp_outs(1, 1, 0, 0));
            chk("R11", "rst_status while on", rst_status, 0);
            settle(3);
            dly_m = $urandom_range(0, 6); dly_s = $urandom_range(0, 6);
            t0 = cyc;
            run_op(0, 1, 0, res);
            chk("R4", "power-down result", res, 1);
            chk("R4", "slave stops before master", int'(mst_rise > slv_rise && slv_rise > t0), 1);
            chk("R4", "outputs after power-down", outs(), exp_outs(0, 0, 1, 1));
            chk("R11", "rst_status while off", rst_status, 1);
            settle(3);
        end

        // R12 same-state requests
        p0 = pulse_total;
        run_op(0, 1, 0, res);
        chk("R12", "off request while off", res, 1);
        chk("R12", "outputs unchanged off", outs(), exp_outs(0, 0, 1, 1));
        chk("R12", "no pulse", pulse_total - p0, 0);

        // R5 / R6 master enable failure
        dly_m = 2; dly_s = 2;
        stuck_m = 1'b1;
        run_op(1, 0, 0, res);
        chk("R5", "master enable timeout", res, 2);
        chk("R6", "outputs after master fail", outs(), exp_outs(0, 0, 0, 1));
        stuck_m = 1'b0;
        settle(12);

        // R7 slave enable failure
        stuck_s = 1'b1;
        run_op(1, 0, 0, res);
        chk("R7", "slave enable timeout", res, 2);
        chk("R7", "outputs after slave fail", outs(), exp_outs(0, 0, 1, 0));
        stuck_s = 1'b0;
        settle(12);

        run_op(1, 0, 0, res);
        chk("R3", "recovery power-up", res, 1);
        chk("R12", "on request while on", 0, 0);
        run_op(1, 0, 0, res);
        chk("R12", "on request while on result", res, 1);
        chk("R12", "outputs unchanged on", outs(), exp_outs(1, 1, 0, 0));

        // R8 master disable failure
        stuck_m = 1'b1;
        run_op(0, 1, 0, res);
        chk("R8", "master disable timeout", res, 2);
        chk("R8", "outputs after master stop fail", outs(), exp_outs(1, 1, 1, 0));
        stuck_m = 1'b0;
        settle(12);

        // R8 slave disable failure
        stuck_s = 1'b1;
        run_op(0, 1, 0, res);
        chk("R8", "slave disable timeout", res, 2);
        chk("R8", "outputs after slave stop fail", outs(), exp_outs(1, 1, 1, 1));
        stuck_s = 1'b0;
        settle(12);
        run_op(0, 1, 0, res);
        chk("R4", "power-down after unwind", res, 1);
        chk("R4", "outputs off after unwind", outs(), exp_outs(0, 0, 1, 1));

        // R9 reset requests
        run_op(1, 0, 0, res);
        chk("R3", "power-up before reset", res, 1);
        p0 = pulse_total; r0 = rst_low_total;
        run_op(0, 0, 1, res);
        chk("R9", "reset cycle result", res, 1);
        chk("R9", "reset cycle pulse", pulse_total - p0, PULSE);
        chk("R9", "reset was asserted", int'(rst_low_total - r0 > PULSE), 1);
        chk("R9", "outputs after reset cycle", outs(), exp_outs(1, 1, 0, 0));
        island_on = 1'b0;
        r0 = rst_low_total;
        run_op(0, 0, 1, res);
        chk("R9", "reset refused island down", res, 2);
        chk("R9", "no reset while refused", rst_low_total - r0, 0);
        chk("R9", "outputs after refusal", outs(), exp_outs(1, 1, 0, 0));
        island_on = 1'b1;

        // R10 priority: all three while on -> reset cycle
        p0 = pulse_total;
        run_op(1, 1, 1, res);
        chk("R10", "all requests while on", res, 1);
        chk("R10", "reset wins pulse", pulse_total - p0, PULSE);
        chk("R10", "ends on", outs(), exp_outs(1, 1, 0, 0));
        // off beats on
        run_op(1, 1, 0, res);
        chk("R10", "off+on while on", res, 1);
        chk("R10", "off wins", outs(), exp_outs(0, 0, 1, 1));
        // while off: reset refused first
        run_op(1, 1, 1, res);
        chk("R9", "reset refused while off", res, 2);
        chk("R9", "outputs off unchanged", outs(), exp_outs(0, 0, 1, 1));
        p0 = pulse_total;
        run_op(1, 1, 0, res);
        chk("R10", "off+on while off", res, 1);
        chk("R10", "off wins no pulse", pulse_total - p0, 0);

        // R10 request during a running sequence is ignored
        @(negedge clk); #1;
        pwr_on_req = 1'b1;
        @(negedge clk); #1;
        pwr_on_req = 1'b0;
        settle(10);
        pwr_off_req = 1'b1;
        @(negedge clk); #1;
        pwr_off_req = 1'b0;
        res = 0;
        for (int i = 0; i < 600; i++) begin
            if (done) begin res = 1; break; end
            if (err)  begin res = 2; break; end
            @(negedge clk); #1;
        end
        chk("R10", "busy power-up completes", res, 1);
        settle(20);
        chk("R10", "off during busy ignored", outs(), exp_outs(1, 1, 0, 0));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule